// File: doc/BRIEF.md
# Stop-Mode Power Sequencer

This block takes a small 8-bit microcontroller into its deepest low-power state and brings it back out. The CPU raises a one-cycle strobe when it decodes a stop instruction. The sequencer accepts that strobe and clears the timer interrupt flags and their enables. It also clears the CPU global interrupt mask so that external events can wake the part. It then stops the main oscillator and gates the CPU and every peripheral clock. Register contents, memory and pins are left alone, and nothing else is touched.

While the part is stopped, four interrupt sources can wake it, each one only if its enable is set. A wake turns the oscillator back on and holds every clock off for a fixed number of stabilization cycles. The block then pulses a completion strobe so that the CPU can take the interrupt vector. A build-time strap makes the stop instruction behave as a no-op and reports that outcome instead. Either of two reset inputs returns the sequencer to normal running at once.

Top module: `stopctl_top`

## Requirements
- R1: After reset the state is run, `osc_en` and `cpu_clk_en` are 1, every bit of `periph_clk_en` is 1, and all five pulse outputs are 0.
- R2: A `stop_req` seen in the run state while `stop_disable` is 0 drives `clr_core_tmr`, `clr_tim16` and `clr_imask` high in that same cycle, for that cycle only.
- R3: From the cycle after an accepted stop, `osc_en` is 0 in the stopping and stopped states, and `cpu_clk_en` and `periph_clk_en` are 0 in every state except run.
- R4: A `stop_req` seen in the run state while `stop_disable` is 1 drives `stop_nop` high for that cycle. No clear pulse is issued, and the state, the oscillator and the clocks stay as in run.
- R5: When a source is both raised and enabled in the stopping or stopped state, the next cycle is the waking state with `osc_en` at 1.
- R6: A raised source whose enable bit is 0 is ignored. The block stays stopped and `osc_en` stays 0.
- R7: The waking state lasts exactly STAB_CYCLES cycles with all clocks gated. `wake_done` pulses in its last cycle, and the following cycle is run with every clock enabled.
- R8: `rst_ext` or `rst_lv`, sampled at any clock edge, leaves the run state with the oscillator on after that edge. Any stabilization count in progress is dropped, so a later wake waits the full STAB_CYCLES again.
- R9: A `stop_req` in any state other than run causes no pulse and no change of state.
- R10: `state_o` encodes the states as run=0, stopping=1, stopped=2 and waking=3.
- R11: The bit positions of `wake_src` and `wake_en` are: bit 0 the external interrupt pin, bit 1 the keyboard, bit 2 the low-voltage indicator, bit 3 the 32 kHz clock-system interrupt. Each of them can wake the part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_ext | input | 1 | External reset, synchronous, active high |
| rst_lv | input | 1 | Low-voltage reset, synchronous, active high |
| stop_req | input | 1 | One-cycle strobe for a decoded stop instruction |
| stop_disable | input | 1 | Build-time strap; 1 turns stop into a no-op |
| wake_src | input | 4 | Raw wake requests (bit order per R11) |
| wake_en | input | 4 | Per-source wake enables |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | NUM_PCLK | Per-peripheral clock gate enables |
| clr_core_tmr | output | 1 | Clears core-timer overflow and real-time flags and their enables |
| clr_tim16 | output | 1 | Clears 16-bit timer status flags and interrupt enables |
| clr_imask | output | 1 | Clears the CPU global interrupt mask |
| stop_nop | output | 1 | Stop was requested while the strap disables it |
| wake_done | output | 1 | Stabilization finished; CPU may vector |
| state_o | output | 2 | Current state (encoding per R10) |

## Verification
The properties take the CPU strobe to be synchronous to `clk` and every input to be driven to a known value from the first edge, with a reset held over that edge. The stimulus changes inputs only between edges and applies reset over the first cycles. It gives `stop_req` as single-cycle pulses, and it also drives the strobe inside the stopped and waking states so that R9 is reached. Wake sources are raised only while the bench expects them to count or to be ignored. Reset is applied mid-stabilization and while stopped, which shows that no count carries over.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    localparam int WAKE_SRC_N = 4;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_STOPPING = 2'd1,
        ST_STOPPED  = 2'd2,
        ST_WAKING   = 2'd3
    } pwr_state_t;

    typedef struct packed {
        logic clr_core;
        logic clr_t16;
        logic clr_imask;
        logic nop;
        logic done;
    } ctl_pulse_t;

    function automatic logic osc_on(pwr_state_t s);
        return (s == ST_RUN) || (s == ST_WAKING);
    endfunction

    function automatic logic clocks_on(pwr_state_t s);
        return s == ST_RUN;
    endfunction

    function automatic logic wake_armed(pwr_state_t s);
        return (s == ST_STOPPING) || (s == ST_STOPPED);
    endfunction

endpackage

// File: rtl/stopctl_wake_qual.sv
module stopctl_wake_qual #(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] en,
    input  logic               armed,
    output logic               hit
);
    logic [NUM_SRC-1:0] qual;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
        assign qual[i] = src[i] & en[i];
    end

    assign hit = armed & (|qual);
endmodule

// File: rtl/stopctl_stab_cnt.sv
module stopctl_stab_cnt #(
    parameter int STAB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expire
);
    localparam int CW = (STAB_CYCLES < 2) ? 1 : $clog2(STAB_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign expire = active && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/stopctl_fsm.sv
module stopctl_fsm
    import stopctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       stop_disable,
    input  logic       wake_hit,
    input  logic       stab_done,
    output pwr_state_t state,
    output ctl_pulse_t pulse
);
    pwr_state_t state_nx;
    logic       in_run;
    logic       accept;

    assign in_run = (state == ST_RUN);
    assign accept = in_run && stop_req && !stop_disable;

    always_comb begin
        pulse           = '0;
        pulse.clr_core  = accept;
        pulse.clr_t16   = accept;
        pulse.clr_imask = accept;
        pulse.nop       = in_run && stop_req && stop_disable;
        pulse.done      = (state == ST_WAKING) && stab_done;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:      if (accept) state_nx = ST_STOPPING;
            ST_STOPPING: state_nx = wake_hit ? ST_WAKING : ST_STOPPED;
            ST_STOPPED:  if (wake_hit) state_nx = ST_WAKING;
            ST_WAKING:   if (stab_done) state_nx = ST_RUN;
            default:     state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end
endmodule

// File: rtl/stopctl_top.sv
module stopctl_top
    import stopctl_pkg::*;
#(
    parameter int STAB_CYCLES = 16,
    parameter int NUM_PCLK    = 7
) (
    input  logic                  clk,
    input  logic                  rst_ext,
    input  logic                  rst_lv,
    input  logic                  stop_req,
    input  logic                  stop_disable,
    input  logic [WAKE_SRC_N-1:0] wake_src,
    input  logic [WAKE_SRC_N-1:0] wake_en,
    output logic                  osc_en,
    output logic                  cpu_clk_en,
    output logic [NUM_PCLK-1:0]   periph_clk_en,
    output logic                  clr_core_tmr,
    output logic                  clr_tim16,
    output logic                  clr_imask,
    output logic                  stop_nop,
    output logic                  wake_done,
    output logic [1:0]            state_o
);
    logic       rst_any;
    logic       wake_hit;
    logic       stab_done;
    pwr_state_t state;
    ctl_pulse_t pulse;

    assign rst_any = rst_ext | rst_lv;

    stopctl_wake_qual #(.NUM_SRC(WAKE_SRC_N)) u_qual (
        .src   (wake_src),
        .en    (wake_en),
        .armed (wake_armed(state)),
        .hit   (wake_hit)
    );

    stopctl_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk    (clk),
        .rst    (rst_any),
        .active (state == ST_WAKING),
        .expire (stab_done)
    );

    stopctl_fsm u_fsm (
        .clk          (clk),
        .rst          (rst_any),
        .stop_req     (stop_req),
        .stop_disable (stop_disable),
        .wake_hit     (wake_hit),
        .stab_done    (stab_done),
        .state        (state),
        .pulse        (pulse)
    );

    assign osc_en     = osc_on(state);
    assign cpu_clk_en = clocks_on(state);

    for (genvar p = 0; p < NUM_PCLK; p++) begin : g_pgate
        assign periph_clk_en[p] = clocks_on(state);
    end

    assign clr_core_tmr = pulse.clr_core;
    assign clr_tim16    = pulse.clr_t16;
    assign clr_imask    = pulse.clr_imask;
    assign stop_nop     = pulse.nop;
    assign wake_done    = pulse.done;
    assign state_o      = state;
endmodule

// File: rtl/stopctl_checker.sv
module stopctl_checker
    import stopctl_pkg::*;
#(
    parameter int STAB_CYCLES = 16,
    parameter int NUM_PCLK    = 7
) (
    input logic                  clk,
    input logic                  rst_ext,
    input logic                  rst_lv,
    input logic                  stop_req,
    input logic                  stop_disable,
    input logic [WAKE_SRC_N-1:0] wake_src,
    input logic [WAKE_SRC_N-1:0] wake_en,
    input logic                  osc_en,
    input logic                  cpu_clk_en,
    input logic [NUM_PCLK-1:0]   periph_clk_en,
    input logic                  clr_core_tmr,
    input logic                  clr_tim16,
    input logic                  clr_imask,
    input logic                  stop_nop,
    input logic                  wake_done,
    input logic [1:0]            state_o
);
    localparam int CW = $clog2(STAB_CYCLES + 1);

    logic          rst_c;
    logic [CW-1:0] wk_len;

    assign rst_c = rst_ext || rst_lv;

    always_ff @(posedge clk) begin
        if (rst_c || state_o != 2'd3) begin
            wk_len <= '0;
        end else begin
            wk_len <= wk_len + 1'b1;
        end
    end

    AST_ACCEPT_TO_STOPPING: assert property (@(posedge clk) disable iff (rst_c)
        clr_core_tmr |=> (state_o == 2'd1)) else $error("accept"); // R2
    AST_CLEARS_TOGETHER: assert property (@(posedge clk) disable iff (rst_c)
        clr_core_tmr |-> (clr_tim16 && clr_imask && !stop_nop)) else $error("clears"); // R2
    AST_OSC_OFF_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst_c)
        clr_imask |=> (!osc_en && !cpu_clk_en)) else $error("osc off"); // R3
    AST_GATED_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (rst_c)
        (state_o != 2'd0) |-> (!cpu_clk_en && periph_clk_en == '0)) else $error("gate"); // R3
    AST_NOP_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst_c)
        stop_nop |=> (state_o == 2'd0 && osc_en && cpu_clk_en)) else $error("nop"); // R4
    AST_WAKE_TO_WAKING: assert property (@(posedge clk) disable iff (rst_c)
        (state_o == 2'd2 && |(wake_src & wake_en)) |=> (state_o == 2'd3 && osc_en)) else $error("wake"); // R5
    AST_UNQUAL_IGNORED: assert property (@(posedge clk) disable iff (rst_c)
        (state_o == 2'd2 && !(|(wake_src & wake_en))) |=> (state_o == 2'd2 && !osc_en)) else $error("unqual"); // R6
    AST_STAB_WINDOW: assert property (@(posedge clk) disable iff (rst_c)
        (state_o == 2'd3) |-> (wk_len < CW'(STAB_CYCLES))) else $error("stab len"); // R7
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst_c)
        wake_done |-> (wk_len == CW'(STAB_CYCLES - 1))) else $error("done time"); // R7
    AST_DONE_TO_RUN: assert property (@(posedge clk) disable iff (rst_c)
        wake_done |=> (state_o == 2'd0 && cpu_clk_en)) else $error("done run"); // R7
    AST_RESET_TO_RUN: assert property (@(posedge clk)
        rst_c |=> (state_o == 2'd0 && osc_en)) else $error("reset"); // R8
    AST_REQ_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (rst_c)
        (state_o != 2'd0 && stop_req) |-> !(clr_core_tmr || stop_nop)) else $error("req ign"); // R9
endmodule

bind stopctl_top stopctl_checker #(
    .STAB_CYCLES (STAB_CYCLES),
    .NUM_PCLK    (NUM_PCLK)
) u_chk (
    .clk           (clk),
    .rst_ext       (rst_ext),
    .rst_lv        (rst_lv),
    .stop_req      (stop_req),
    .stop_disable  (stop_disable),
    .wake_src      (wake_src),
    .wake_en       (wake_en),
    .osc_en        (osc_en),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .clr_core_tmr  (clr_core_tmr),
    .clr_tim16     (clr_tim16),
    .clr_imask     (clr_imask),
    .stop_nop      (stop_nop),
    .wake_done     (wake_done),
    .state_o       (state_o)
);

// File: tb/stopctl_top_bench.sv
`timescale 1ns/1ps
module stopctl_top_bench;
    localparam int S  = 5;
    localparam int NP = 7;
    localparam logic [1:0] E_RUN = 2'd0, E_STPG = 2'd1, E_STPD = 2'd2, E_WAKE = 2'd3;

    typedef struct {
        logic [1:0] st;
        logic       osc;
        logic       clk_on;
        logic       clr;
        logic       nop;
        logic       done;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_ext = 1'b1, rst_lv = 1'b0, stop_req = 1'b0, stop_disable = 1'b0;
    logic [3:0] wake_src = '0, wake_en = '0;
    logic osc_en, cpu_clk_en, clr_core_tmr, clr_tim16, clr_imask, stop_nop, wake_done;
    logic [NP-1:0] periph_clk_en;
    logic [1:0] state_o;

    int checks = 0, failures = 0;
    bit finished = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    stopctl_top #(.STAB_CYCLES(S), .NUM_PCLK(NP)) u_stopctl_top (
        .clk(clk), .rst_ext(rst_ext), .rst_lv(rst_lv), .stop_req(stop_req),
        .stop_disable(stop_disable), .wake_src(wake_src), .wake_en(wake_en),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .clr_core_tmr(clr_core_tmr), .clr_tim16(clr_tim16), .clr_imask(clr_imask),
        .stop_nop(stop_nop), .wake_done(wake_done), .state_o(state_o)
    );

    function automatic exp_t mk(logic [1:0] st, logic osc, logic ck, logic clr,
                                logic nop, logic done, string tag);
        exp_t e;
        e.st = st; e.osc = osc; e.clk_on = ck; e.clr = clr; e.nop = nop; e.done = done; e.tag = tag;
        return e;
    endfunction

    function automatic exp_t e_run(string t);    return mk(E_RUN, 1, 1, 0, 0, 0, t); endfunction
    function automatic exp_t e_accept(string t); return mk(E_RUN, 1, 1, 1, 0, 0, t); endfunction
    function automatic exp_t e_nop(string t);    return mk(E_RUN, 1, 1, 0, 1, 0, t); endfunction
    function automatic exp_t e_stpg(string t);   return mk(E_STPG, 0, 0, 0, 0, 0, t); endfunction
    function automatic exp_t e_stpd(string t);   return mk(E_STPD, 0, 0, 0, 0, 0, t); endfunction
    function automatic exp_t e_wake(logic d, string t); return mk(E_WAKE, 1, 0, 0, 0, d, t); endfunction

    // driver: one call per clock cycle, expectation describes that cycle
    task automatic cyc(logic rx, logic rl, logic rq, logic dis, logic [3:0] src,
                       logic [3:0] en, exp_t e, bit chk);
        @(negedge clk);
        #1;
        rst_ext = rx; rst_lv = rl; stop_req = rq; stop_disable = dis;
        wake_src = src; wake_en = en;
        if (chk) sb.push_back(e);
    endtask

    task automatic idle(exp_t e);
        cyc(0, 0, 0, 0, 4'h0, 4'h0, e, 1);
    endtask

    // monitor: pops the expectation of the current cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                logic [5+NP-1:0] act, exp;
                e = sb.pop_front();
                act = {state_o, osc_en, cpu_clk_en, periph_clk_en,
                       (clr_core_tmr & clr_tim16 & clr_imask) | (clr_core_tmr ^ clr_tim16) | (clr_tim16 ^ clr_imask)} ;
                exp = {e.st, e.osc, e.clk_on, {NP{e.clk_on}}, e.clr};
                checks++;
                if (act !== exp || stop_nop !== e.nop || wake_done !== e.done) begin
                    failures++;
                    $display("FAIL %s: act st=%0d osc=%0b cpu=%0b pclk=%b clr=%0b%0b%0b nop=%0b done=%0b | exp st=%0d osc=%0b clk=%0b clr=%0b nop=%0b done=%0b",
                             e.tag, state_o, osc_en, cpu_clk_en, periph_clk_en, clr_core_tmr,
                             clr_tim16, clr_imask, stop_nop, wake_done,
                             e.st, e.osc, e.clk_on, e.clr, e.nop, e.done);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        exp_t nx;
        nx = e_run("none");
        cyc(1, 0, 0, 0, 4'h0, 4'h0, nx, 0);
        cyc(1, 0, 0, 0, 4'h0, 4'h0, nx, 0);
        idle(e_run("R1 R10"));
        idle(e_run("R1"));

        // normal stop, ignored wake, then enabled low-voltage-indicator wake
        cyc(0, 0, 1, 0, 4'h0, 4'h0, e_accept("R2"), 1);
        idle(e_stpg("R3 R10"));
        cyc(0, 0, 1, 0, 4'h0, 4'h0, e_stpd("R9"), 1);
        cyc(0, 0, 0, 0, 4'h1, 4'h0, e_stpd("R9"), 1);
        cyc(0, 0, 0, 0, 4'h0, 4'hE, e_stpd("R6"), 1);
        cyc(0, 0, 0, 0, 4'h4, 4'h4, e_stpd("R6"), 1);
        for (int k = 0; k < S; k++)
            cyc(0, 0, (k == 1), 0, 4'h0, 4'h0, e_wake(k == S - 1, (k == 1) ? "R9" : "R5 R7"), 1);
        idle(e_run("R7"));

        // strap set: stop becomes a no-op
        cyc(0, 0, 1, 1, 4'h0, 4'h0, e_nop("R4"), 1);
        idle(e_run("R4"));
        idle(e_run("R4"));

        // wake from the 32 kHz source while still in the stopping cycle
        cyc(0, 0, 1, 0, 4'h0, 4'h0, e_accept("R2"), 1);
        cyc(0, 0, 0, 0, 4'h8, 4'h8, e_stpg("R11"), 1);
        for (int k = 0; k < S; k++)
            idle(e_wake(k == S - 1, "R11"));
        idle(e_run("R7"));

        // keyboard wake, then low-voltage reset mid-stabilization
        cyc(0, 0, 1, 0, 4'h0, 4'h0, e_accept("R2"), 1);
        idle(e_stpg("R3"));
        cyc(0, 0, 0, 0, 4'h2, 4'h2, e_stpd("R11"), 1);
        idle(e_wake(0, "R8"));
        cyc(0, 1, 0, 0, 4'h0, 4'h0, e_wake(0, "R8"), 1);
        idle(e_run("R8"));
        cyc(0, 0, 1, 0, 4'h0, 4'h0, e_accept("R8"), 1);
        cyc(0, 0, 0, 0, 4'h1, 4'h1, e_stpg("R11"), 1);
        for (int k = 0; k < S; k++)
            idle(e_wake(k == S - 1, "R8"));
        idle(e_run("R8"));

        // external reset while stopped
        cyc(0, 0, 1, 0, 4'h0, 4'h0, e_accept("R2"), 1);
        idle(e_stpg("R3"));
        idle(e_stpd("R3"));
        cyc(1, 0, 0, 0, 4'h0, 4'h0, e_stpd("R8"), 1);
        idle(e_run("R8"));
        idle(e_run("R8"));

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule